// File: doc/BRIEF.md
# Eight-Key Even-Odd Merge Sorter

This block puts eight unsigned keys into ascending order. Its keys have a width set by a parameter. It is built from nineteen compare-exchange elements wired as a recursive even-odd merge. There are two four-key sorters, and a merger combines their results. The merger sorts the even-indexed and the odd-indexed halves separately. A last column of comparators then fixes adjacent pairs. The network has six comparator levels.

A parameter chooses how the block is timed:
- When it is set, a register follows every level. A new set of keys is taken every cycle, and each result appears exactly six cycles later with its valid flag.
- When it is cleared, the network is purely combinational, and the result is valid in the same cycle as the input.

Top module: `oem_sorter8`

## Requirements
- R1: Every compare-exchange element drives the smaller of its two inputs on its lower-index output and the larger on its higher-index output.
- R2: Whenever `vld_o` is high, `keys_o[0]` through `keys_o[7]` are in non-decreasing order. Index 0 holds the smallest key.
- R3: The output set is a permutation of the input set. Equal keys are neither lost nor duplicated.
- R4: All 256 input vectors whose keys are each either zero or the all-ones value come out sorted.
- R5: With `PIPE_EN=1`, `vld_o` equals `vld_i` from exactly 6 cycles earlier. The keys shown with it are the sorted form of the keys sampled in that cycle.
- R6: With `PIPE_EN=1`, input sets may arrive on consecutive cycles, with or without idle cycles between them. Each one is sorted independently, in order.
- R7: With `PIPE_EN=0`, `vld_o` follows `vld_i` in the same cycle, and `keys_o` is the sorted form of the present `keys_i`.
- R8: While `rst_ni` is low and after it is released, `vld_o` stays low until valid input has passed through the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Input key set is valid |
| keys_i | input | 8 x KEY_W | Unsorted keys, element i is key i |
| vld_o | output | 1 | Output key set is valid |
| keys_o | output | 8 x KEY_W | Sorted keys, element 0 is the smallest |

## Verification
The exhaustive sweep feeds all 256 patterns of zeros and maximum-value keys. This sweep decides correctness for the whole comparator network. Directed sets separate the cases that a wrong network could confuse:
- a single swapped lower pair, which catches a reversed comparator
- a fully descending set
- all-equal keys
- heavy duplicates

Random sets are drawn from small and from full-width ranges. They arrive back to back with random idle gaps, which exposes latency errors, valid-alignment errors and cross-talk between neighbouring sets. A pipelined instance and a combinational instance run side by side on the same stimulus.

// File: rtl/oem_pkg.sv
package oem_pkg;
  localparam int unsigned NKEYS  = 8;
  localparam int unsigned LEVELS = 6;

  // partner index of position i at comparator level lvl (self = pass-through)
  function automatic int unsigned partner(input int unsigned lvl, input int unsigned i);
    int unsigned p;
    p = i;
    case (lvl)
      0: p = i ^ 1;
      1: p = i ^ 2;
      2: p = ((i % 4) == 1 || (i % 4) == 2) ? (i ^ 3) : i;
      3: p = i ^ 4;
      4: p = (i >= 2 && i <= 5) ? ((i < 4) ? i + 2 : i - 2) : i;
      5: p = (i >= 1 && i <= 6) ? (((i % 2) == 1) ? i + 1 : i - 1) : i;
      default: p = i;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/cmp_xchg.sv
module cmp_xchg #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);
  logic swap;
  assign swap = a_i > b_i;
  assign lo_o = swap ? b_i : a_i;
  assign hi_o = swap ? a_i : b_i;

  always_comb begin
    assert_lo_le_hi_R1: assert (lo_o <= hi_o);
    assert_perm_R3: assert ((lo_o == a_i && hi_o == b_i) || (lo_o == b_i && hi_o == a_i));
  end
endmodule

// File: rtl/sort_level.sv
module sort_level
  import oem_pkg::*;
#(
  parameter int unsigned W    = 16,
  parameter int unsigned LVL  = 0,
  parameter bit          PIPE = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic [NKEYS-1:0][W-1:0] keys_i,
  output logic                    vld_o,
  output logic [NKEYS-1:0][W-1:0] keys_o
);
  logic [NKEYS-1:0][W-1:0] net;

  for (genvar i = 0; i < NKEYS; i++) begin : g_pos
    localparam int unsigned P = partner(LVL, i);
    if (P > i) begin : g_cx
      cmp_xchg #(.W(W)) u_cx (
        .a_i (keys_i[i]),
        .b_i (keys_i[P]),
        .lo_o(net[i]),
        .hi_o(net[P])
      );
    end else if (P == i) begin : g_pass
      assign net[i] = keys_i[i];
    end
  end

  if (PIPE) begin : g_reg
    logic armed_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o   <= 1'b0;
        keys_o  <= '0;
        armed_q <= 1'b0;
      end else begin
        vld_o   <= vld_i;
        keys_o  <= net;
        armed_q <= 1'b1;
      end
    end

    assert_lvl_delay_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed_q |-> (vld_o == $past(vld_i)));
  end else begin : g_comb
    assign vld_o  = vld_i;
    assign keys_o = net;
  end
endmodule

// File: rtl/oem_sorter8.sv
module oem_sorter8
  import oem_pkg::*;
#(
  parameter int unsigned KEY_W   = 16,
  parameter bit          PIPE_EN = 1'b1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        vld_i,
  input  logic [NKEYS-1:0][KEY_W-1:0] keys_i,
  output logic                        vld_o,
  output logic [NKEYS-1:0][KEY_W-1:0] keys_o
);
  logic [LEVELS:0]                        vld_c;
  logic [LEVELS:0][NKEYS-1:0][KEY_W-1:0] key_c;

  assign vld_c[0] = vld_i;
  assign key_c[0] = keys_i;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    sort_level #(.W(KEY_W), .LVL(l), .PIPE(PIPE_EN)) u_lvl (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .vld_i (vld_c[l]),
      .keys_i(key_c[l]),
      .vld_o (vld_c[l+1]),
      .keys_o(key_c[l+1])
    );
  end

  assign vld_o  = vld_c[LEVELS];
  assign keys_o = key_c[LEVELS];

  logic sorted_ok;
  always_comb begin
    sorted_ok = 1'b1;
    for (int i = 0; i < NKEYS - 1; i++)
      if (keys_o[i] > keys_o[i+1]) sorted_ok = 1'b0;
  end

  assert_sorted_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> sorted_ok);

  if (PIPE_EN) begin : g_rst_chk
    assert_idle_after_rst_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !vld_c[LEVELS-1] |=> !vld_o);
  end
endmodule

// File: tb/sim_oem_sorter8.sv
module sim_oem_sorter8;
  localparam int unsigned W = 16;
  localparam int unsigned N = 8;
  typedef logic [N-1:0][W-1:0] keyset_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic vld_i = 1'b0;
  keyset_t keys_i = '0;
  logic vld_p, vld_c;
  keyset_t keys_p, keys_c;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  oem_sorter8 #(.KEY_W(W), .PIPE_EN(1'b1)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(vld_i), .keys_i(keys_i),
    .vld_o(vld_p), .keys_o(keys_p));

  oem_sorter8 #(.KEY_W(W), .PIPE_EN(1'b0)) u1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(vld_i), .keys_i(keys_i),
    .vld_o(vld_c), .keys_o(keys_c));

  function automatic keyset_t ref_sort(input keyset_t k);
    keyset_t s = k;
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N - 1 - a; b++)
        if (s[b] > s[b+1]) begin
          logic [W-1:0] t = s[b];
          s[b] = s[b+1];
          s[b+1] = t;
        end
    return s;
  endfunction

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s valid: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic chk_keys(input string tag, input keyset_t act, input keyset_t exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s keys: got %h expected %h", tag, act, exp);
    end
  endtask

  // ring of what was driven, indexed by step number mod 8
  logic    ring_v[8];
  keyset_t ring_k[8];
  string   ring_t[8];
  int      step_n = 0;

  task automatic step(input logic v, input keyset_t k, input string tag);
    int old;
    @(negedge clk_i);
    if (step_n >= 6) begin
      old = (step_n - 6) % 8;
      chk_bit({ring_t[old], " R5"}, vld_p, ring_v[old]);
      if (ring_v[old] && vld_p) chk_keys({ring_t[old], " R5"}, keys_p, ref_sort(ring_k[old]));
    end else begin
      chk_bit("R8 pipe fill", vld_p, 1'b0);
    end
    vld_i  = v;
    keys_i = k;
    ring_v[step_n % 8] = v;
    ring_k[step_n % 8] = k;
    ring_t[step_n % 8] = tag;
    step_n++;
    #1;
    chk_bit({tag, " R7"}, vld_c, v);
    if (v) chk_keys({tag, " R7"}, keys_c, ref_sort(k));
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    keyset_t k;
    void'($urandom(32'h5EED_0A17));
    repeat (3) @(negedge clk_i);
    chk_bit("R8 in reset", vld_p, 1'b0);
    chk_bit("R8 in reset comb", vld_c, 1'b0);
    rst_ni = 1'b1;

    // R1: only the lowest pair out of order
    for (int i = 0; i < N; i++) k[i] = W'(10 * i);
    k[0] = 16'd15; k[1] = 16'd5;
    step(1'b1, k, "R1 lower pair");
    for (int i = 0; i < N; i++) k[i] = W'(N - i);
    step(1'b1, k, "R1 descending");
    k = '0;
    step(1'b1, k, "R2 all zero");
    k = '1;
    step(1'b1, k, "R2 all max");
    for (int i = 0; i < N; i++) k[i] = 16'h0777;
    step(1'b1, k, "R3 all equal");
    for (int i = 0; i < N; i++) k[i] = W'(i % 3);
    step(1'b1, k, "R3 duplicates");
    step(1'b0, k, "R6 gap");
    step(1'b0, k, "R6 gap");

    // R4: exhaustive zero/max sweep, back to back
    for (int p = 0; p < 256; p++) begin
      for (int j = 0; j < N; j++) k[j] = p[j] ? '1 : '0;
      step(1'b1, k, "R4 zero-one");
    end

    // R6: random sets, random idle gaps, small and full ranges
    for (int r = 0; r < 400; r++) begin
      for (int j = 0; j < N; j++)
        k[j] = (r % 2 == 0) ? W'($urandom % 4) : W'($urandom);
      step(($urandom % 5) != 0, k, "R6 random R3");
    end

    for (int f = 0; f < 8; f++) step(1'b0, '0, "R6 flush");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule